// File: doc/BRIEF.md
# Asymmetric Dual-Issue Syllable Marshaller

This block sits at the end of instruction fetch in a machine whose instructions are one, two or three syllables long. It holds a six-syllable prefetch queue, which memory refills two syllables per beat through a valid/ready port. Every cycle it presents the oldest complete instruction to lane a, which accepts all three lengths. When the data paths and the instruction mix allow it, it also presents the instruction that follows to lane b. Lane b has fewer resources than lane a. It takes only one- or two-syllable instructions. Every syllable it receives must come from queue slots 1 to 3. It can be closed to memory-reference instructions through a lock input. When lane b cannot take the next instruction, that instruction waits and reaches lane a on a later cycle. Issue therefore falls back to one instruction per cycle for some instruction mixes.

The head of the queue is tracked by a three-state machine:
- `ST_EMPTY`: the queue holds nothing.
- `ST_WAIT`: the queue holds part of the head instruction.
- `ST_READY`: the whole head instruction is present.

The transitions are:
- EMPTY→EMPTY: no beat arrives.
- EMPTY→WAIT: a beat arrives but the head is still incomplete.
- EMPTY→READY: a beat completes the head.
- WAIT→WAIT: the head is still incomplete.
- WAIT→READY: a refill completes the head.
- READY→READY: after issue and refill, the new head is complete.
- READY→WAIT: the remaining syllables do not complete the new head.
- READY→EMPTY: everything was issued and no beat arrived.

The state is recomputed each cycle from the queue contents the next clock edge will hold. Downstream decoders read the two lane buses and their valid flags. The `consume` count is the number of syllables that leave the queue at the next edge.

Top module: `sylm_marshaller`

## Requirements
- R1: The length of an instruction is coded in bits [15:14] of its first syllable: 00 means one syllable, 01 means two, 10 means three, and 11 is treated as one. Bit 13 of the first syllable marks a memory-reference instruction.
- R2: The queue holds six syllables. `mem_ready` is high exactly when the queue holds four syllables or fewer. A beat is taken only when `mem_valid` and `mem_ready` are both high. `mem_data[15:0]` enters the queue ahead of `mem_data[31:16]`, and a beat offered while `mem_ready` is low changes nothing.
- R3: `a_valid` is high only when every syllable of the head instruction is present and `stall_a` is low. `a_len` gives the head length. `a_instr` carries syllable k at bits [47-16k:32-16k].
- R4: Lane b is offered the instruction that directly follows lane a's. It issues only if its length is one or two and all of its syllables lie in slots 1 to 3 and are present. So three-plus-one dual-issues, while three-plus-two and one-plus-three issue lane a alone. `b_instr` carries syllable k at bits [31-16k:16-16k].
- R5: While `lock_mem_b` is high, an instruction with the memory-reference bit set never issues on lane b. It stays queued and issues on lane a on the next cycle that lane a issues.
- R6: A high `stall_a` blocks all issue. A high `stall_b` blocks only lane b, and lane a still issues.
- R7: `consume` equals `a_len` plus `b_len` for the lanes that issue, and 0 when none does. At the next clock edge that many syllables leave the front of the queue, and the rest move forward in order. Lane a always holds the older of two instructions issued together.
- R8: After reset the queue is empty, both valid flags are low, `consume` is 0 and `mem_ready` is high.
- R9: Syllable positions of `a_instr` and `b_instr` beyond the issued length read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_valid | input | 1 | Refill beat offered |
| mem_data | input | 32 | Two refill syllables, low half first |
| mem_ready | output | 1 | Queue can take a beat |
| stall_a | input | 1 | Lane a downstream stall |
| stall_b | input | 1 | Lane b downstream stall |
| lock_mem_b | input | 1 | Bar memory-reference instructions from lane b |
| a_valid | output | 1 | Lane a instruction issues |
| a_len | output | 2 | Lane a length in syllables |
| a_instr | output | 48 | Lane a syllables, first at the top |
| b_valid | output | 1 | Lane b instruction issues |
| b_len | output | 2 | Lane b length in syllables |
| b_instr | output | 32 | Lane b syllables, first at the top |
| consume | output | 3 | Syllables retired at the next edge |

## Verification
The lane buses, valid flags, `consume` and `mem_ready` are combinational from the registered queue and the current stall and lock inputs. They are therefore due in the same cycle as the inputs that cause them. A refill beat or a retirement shows in the outputs only after the next rising edge. The bench changes inputs on the falling edge and samples one nanosecond later. It expects the effect of a beat or a retirement only at the falling edge that follows the rising edge which took it. Each scenario fills the queue while lane a is stalled and then opens issue one cycle at a time, so every cycle's expected lane contents are known in advance.

// File: rtl/sylm_pkg.sv
package sylm_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2
    } sylm_state_t;

    // Length code of a first syllable, in syllables (R1).
    function automatic logic [1:0] len_of(input logic [1:0] code);
        logic [1:0] n;
        unique case (code)
            2'b00:   n = 2'd1;
            2'b01:   n = 2'd2;
            2'b10:   n = 2'd3;
            default: n = 2'd1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sylm_buffer.sv
module sylm_buffer #(
    parameter int SYL_W = 16,
    parameter int DEPTH = 6,
    parameter int FILL  = 2,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CNT_W-1:0]            take,
    input  logic                        fill_en,
    input  logic [FILL-1:0][SYL_W-1:0]  fill_data,
    output logic [DEPTH-1:0][SYL_W-1:0] slots,
    output logic [CNT_W-1:0]            count,
    output logic [CNT_W-1:0]            nxt_count,
    output logic [SYL_W-1:0]            nxt_head,
    output logic                        fill_ok
);

    localparam int FILL_LIMIT = DEPTH - FILL;

    logic [DEPTH-1:0][SYL_W-1:0] nxt_slots;
    int                          kept;

    always_comb begin
        kept      = int'(count) - int'(take);
        nxt_slots = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i < kept) begin
                if (i + int'(take) < DEPTH) begin
                    nxt_slots[i] = slots[i + int'(take)];
                end
            end else if (fill_en && (i - kept) < FILL) begin
                nxt_slots[i] = fill_data[i - kept];
            end
        end
        nxt_count = CNT_W'(kept + (fill_en ? FILL : 0));
    end

    assign nxt_head = nxt_slots[0];
    assign fill_ok  = (int'(count) <= FILL_LIMIT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots <= '0;
            count <= '0;
        end else begin
            slots <= nxt_slots;
            count <= nxt_count;
        end
    end

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);

    a_r7_take_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        take <= count);

endmodule

// File: rtl/sylm_picker.sv
module sylm_picker
    import sylm_pkg::*;
#(
    parameter int SYL_W   = 16,
    parameter int DEPTH   = 6,
    parameter int A_MAX   = 3,
    parameter int B_MAX   = 2,
    parameter int B_REACH = 4,
    parameter int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DEPTH-1:0][SYL_W-1:0] slots,
    input  logic [CNT_W-1:0]            count,
    input  logic                        head_ready,
    input  logic                        stall_a,
    input  logic                        stall_b,
    input  logic                        lock_mem_b,
    output logic                        a_valid,
    output logic [1:0]                  a_len,
    output logic [A_MAX*SYL_W-1:0]      a_instr,
    output logic                        b_valid,
    output logic [1:0]                  b_len,
    output logic [B_MAX*SYL_W-1:0]      b_instr,
    output logic [CNT_W-1:0]            take
);

    localparam int MEM_BIT = SYL_W - 3;

    logic [SYL_W-1:0] b_head;
    logic             b_mem;
    logic             b_fits;
    int               b_pos;

    // Lane a: head of the queue.
    always_comb begin
        a_len   = len_of(slots[0][SYL_W-1 -: 2]);
        a_valid = head_ready && !stall_a;
        a_instr = '0;
        for (int k = 0; k < A_MAX; k++) begin
            if (k < int'(a_len) && k < DEPTH) begin
                a_instr[(A_MAX-1-k)*SYL_W +: SYL_W] = slots[k];
            end
        end
    end

    // Lane b: the instruction right after lane a, inside the reach window.
    always_comb begin
        b_pos  = int'(a_len);
        b_head = (b_pos < DEPTH) ? slots[b_pos] : '0;
        b_len  = len_of(b_head[SYL_W-1 -: 2]);
        b_mem  = b_head[MEM_BIT];
        b_fits = (int'(b_len) <= B_MAX)
              && (b_pos + int'(b_len) <= B_REACH)
              && (b_pos + int'(b_len) <= int'(count));
        b_valid = a_valid && !stall_b && b_fits && !(lock_mem_b && b_mem);
        b_instr = '0;
        for (int k = 0; k < B_MAX; k++) begin
            if (k < int'(b_len) && (b_pos + k) < DEPTH) begin
                b_instr[(B_MAX-1-k)*SYL_W +: SYL_W] = slots[b_pos + k];
            end
        end
    end

    always_comb begin
        if (!a_valid) begin
            take = '0;
        end else if (b_valid) begin
            take = CNT_W'(int'(a_len) + int'(b_len));
        end else begin
            take = CNT_W'(a_len);
        end
    end

    a_r4_b_follows_a: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid |-> a_valid);

    a_r4_b_in_reach: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid |-> (int'(a_len) + int'(b_len) <= B_REACH) && (int'(b_len) <= B_MAX));

    a_r5_no_mem_on_b: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_mem_b && b_valid) |-> !b_instr[B_MAX*SYL_W-3]);

    a_r6_stall_a_holds: assert property (@(posedge clk) disable iff (!rst_n)
        stall_a |-> (take == '0) && !b_valid);

endmodule

// File: rtl/sylm_marshaller.sv
module sylm_marshaller
    import sylm_pkg::*;
#(
    parameter int SYL_W     = 16,
    parameter int BUF_DEPTH = 6,
    parameter int FILL_N    = 2,
    parameter int A_MAX     = 3,
    parameter int B_MAX     = 2,
    parameter int B_REACH   = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               mem_valid,
    input  logic [FILL_N*SYL_W-1:0]            mem_data,
    output logic                               mem_ready,
    input  logic                               stall_a,
    input  logic                               stall_b,
    input  logic                               lock_mem_b,
    output logic                               a_valid,
    output logic [1:0]                         a_len,
    output logic [A_MAX*SYL_W-1:0]             a_instr,
    output logic                               b_valid,
    output logic [1:0]                         b_len,
    output logic [B_MAX*SYL_W-1:0]             b_instr,
    output logic [$clog2(BUF_DEPTH+1)-1:0]     consume
);

    localparam int CNT_W = $clog2(BUF_DEPTH + 1);

    logic [BUF_DEPTH-1:0][SYL_W-1:0] slots;
    logic [FILL_N-1:0][SYL_W-1:0]    fill_data;
    logic [CNT_W-1:0]                count;
    logic [CNT_W-1:0]                nxt_count;
    logic [SYL_W-1:0]                nxt_head;
    logic                            fill_ok;
    logic                            fill_en;
    logic                            head_ready;
    logic                            nxt_head_full;
    sylm_state_t                     state;
    sylm_state_t                     nxt_state;

    assign fill_data = mem_data;
    assign fill_en   = mem_valid && fill_ok;

    sylm_buffer #(
        .SYL_W (SYL_W),
        .DEPTH (BUF_DEPTH),
        .FILL  (FILL_N),
        .CNT_W (CNT_W)
    ) u_buffer (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (consume),
        .fill_en   (fill_en),
        .fill_data (fill_data),
        .slots     (slots),
        .count     (count),
        .nxt_count (nxt_count),
        .nxt_head  (nxt_head),
        .fill_ok   (fill_ok)
    );

    sylm_picker #(
        .SYL_W   (SYL_W),
        .DEPTH   (BUF_DEPTH),
        .A_MAX   (A_MAX),
        .B_MAX   (B_MAX),
        .B_REACH (B_REACH),
        .CNT_W   (CNT_W)
    ) u_picker (
        .clk        (clk),
        .rst_n      (rst_n),
        .slots      (slots),
        .count      (count),
        .head_ready (head_ready),
        .stall_a    (stall_a),
        .stall_b    (stall_b),
        .lock_mem_b (lock_mem_b),
        .a_valid    (a_valid),
        .a_len      (a_len),
        .a_instr    (a_instr),
        .b_valid    (b_valid),
        .b_len      (b_len),
        .b_instr    (b_instr),
        .take       (consume)
    );

    // Head-state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
        end else begin
            state <= nxt_state;
        end
    end

    // Next-state decision from the queue contents after this edge.
    always_comb begin
        nxt_head_full = (int'(nxt_count) >= int'(len_of(nxt_head[SYL_W-1 -: 2])));
        nxt_state     = state;
        unique case (state)
            ST_EMPTY: begin
                if (nxt_count == '0)  nxt_state = ST_EMPTY;
                else if (nxt_head_full) nxt_state = ST_READY;
                else                  nxt_state = ST_WAIT;
            end
            ST_WAIT: begin
                if (nxt_head_full)    nxt_state = ST_READY;
                else                  nxt_state = ST_WAIT;
            end
            ST_READY: begin
                if (nxt_count == '0)  nxt_state = ST_EMPTY;
                else if (nxt_head_full) nxt_state = ST_READY;
                else                  nxt_state = ST_WAIT;
            end
            default: nxt_state = ST_EMPTY;
        endcase
    end

    // Outputs driven by the state.
    always_comb begin
        head_ready = (state == ST_READY);
        mem_ready  = fill_ok;
    end

    a_r3_ready_means_complete: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY) |-> (int'(count) >= int'(len_of(slots[0][SYL_W-1 -: 2]))));

    a_r3_no_issue_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_READY) |-> !a_valid);

    a_r2_beat_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready && consume == '0) |=> count == $past(count));

    a_r7_count_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_valid) |=> int'(count) == int'($past(count)) - int'($past(consume)));

endmodule

// File: tb/sylm_marshaller_tb.sv
module sylm_marshaller_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mem_valid;
    logic [31:0] mem_data;
    logic        mem_ready;
    logic        stall_a, stall_b, lock_mem_b;
    logic        a_valid, b_valid;
    logic [1:0]  a_len, b_len;
    logic [47:0] a_instr;
    logic [31:0] b_instr;
    logic [2:0]  consume;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sylm_marshaller u_dut (
        .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_data(mem_data),
        .mem_ready(mem_ready), .stall_a(stall_a), .stall_b(stall_b),
        .lock_mem_b(lock_mem_b), .a_valid(a_valid), .a_len(a_len),
        .a_instr(a_instr), .b_valid(b_valid), .b_len(b_len),
        .b_instr(b_instr), .consume(consume)
    );

    function automatic logic [15:0] syl(input logic [1:0] lc, input logic m,
                                        input logic [12:0] tag);
        return {lc, m, tag};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; mem_valid = 1'b0; mem_data = '0;
        stall_a = 1'b1; stall_b = 1'b0; lock_mem_b = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Loads six syllables while lane a is stalled; ends on a falling edge.
    task automatic fill6(input logic [15:0] s0, s1, s2, s3, s4, s5);
        mem_valid = 1'b1; mem_data = {s1, s0}; @(negedge clk);
        mem_data = {s3, s2}; @(negedge clk);
        mem_data = {s5, s4}; @(negedge clk);
        mem_valid = 1'b0; #1;
    endtask

    task automatic open_issue(); stall_a = 1'b0; #1; endtask
    task automatic close_issue(); @(negedge clk); stall_a = 1'b1; #1; endtask

    task automatic t_reset();
        do_reset(); #1;
        chk("R8", "a_valid", a_valid, 0);
        chk("R8", "b_valid", b_valid, 0);
        chk("R8", "consume", consume, 0);
        chk("R8", "mem_ready", mem_ready, 1);
    endtask

    task automatic t_three_one();
        logic [15:0] h = syl(2'b10, 0, 13'h101);
        logic [15:0] x = syl(2'b00, 0, 13'h104);
        do_reset();
        fill6(h, 16'h0102, 16'h0103, x, 16'h0005, 16'h0006);
        chk("R6", "stalled consume", consume, 0);
        chk("R2", "full mem_ready", mem_ready, 0);
        open_issue();
        chk("R4", "3+1 a_len", a_len, 3);
        chk("R3", "3+1 a_instr", a_instr, {h, 16'h0102, 16'h0103});
        chk("R4", "3+1 b_valid", b_valid, 1);
        chk("R9", "3+1 b_instr", b_instr, {x, 16'h0000});
        chk("R7", "3+1 consume", consume, 4);
        close_issue();
        chk("R7", "3+1 next head", a_instr, {16'h0005, 32'h0});
    endtask

    task automatic t_three_two();
        logic [15:0] h = syl(2'b10, 0, 13'h201);
        logic [15:0] x = syl(2'b01, 0, 13'h204);
        do_reset();
        fill6(h, 16'h0202, 16'h0203, x, 16'h0205, 16'h0006);
        open_issue();
        chk("R4", "3+2 b_valid", b_valid, 0);
        chk("R7", "3+2 consume", consume, 3);
        close_issue();
        chk("R7", "3+2 b head moved to a", a_instr, {x, 16'h0205, 16'h0000});
        chk("R3", "3+2 a_len later", a_len, 2);
    endtask

    task automatic t_short_pairs();
        logic [15:0] p = syl(2'b01, 0, 13'h301);
        logic [15:0] q = syl(2'b01, 0, 13'h303);
        logic [15:0] r = syl(2'b00, 0, 13'h305);
        logic [15:0] t = syl(2'b10, 0, 13'h306);
        do_reset();
        fill6(p, 16'h0302, q, 16'h0304, r, t);
        open_issue();
        chk("R4", "2+2 b_instr", b_instr, {q, 16'h0304});
        chk("R7", "2+2 consume", consume, 4);
        @(negedge clk); #1;
        chk("R4", "1+3 b_valid", b_valid, 0);
        chk("R9", "1-syl a_instr", a_instr, {r, 32'h0});
        chk("R7", "1+3 consume", consume, 1);
        @(negedge clk); #1;
        chk("R3", "incomplete 3-syl a_valid", a_valid, 0);
        stall_a = 1'b1;
    endtask

    task automatic t_code11_and_one_two();
        logic [15:0] h = syl(2'b11, 0, 13'h401);
        logic [15:0] x = syl(2'b01, 0, 13'h402);
        do_reset();
        fill6(h, x, 16'h0403, 16'h0004, 16'h0005, 16'h0006);
        open_issue();
        chk("R1", "code 11 a_len", a_len, 1);
        chk("R4", "1+2 b_len", b_len, 2);
        chk("R7", "1+2 consume", consume, 3);
        close_issue();
    endtask

    task automatic t_stall_b();
        logic [15:0] h = syl(2'b00, 0, 13'h501);
        do_reset();
        fill6(h, syl(2'b00, 0, 13'h502), 16'h0, 16'h0, 16'h0, 16'h0);
        stall_b = 1'b1;
        open_issue();
        chk("R6", "stall_b a_valid", a_valid, 1);
        chk("R6", "stall_b b_valid", b_valid, 0);
        chk("R6", "stall_b consume", consume, 1);
        close_issue();
        stall_b = 1'b0;
    endtask

    task automatic t_lock();
        logic [15:0] a = syl(2'b00, 0, 13'h601);
        logic [15:0] m = syl(2'b00, 1, 13'h602);
        logic [15:0] c = syl(2'b00, 0, 13'h603);
        do_reset();
        fill6(a, m, c, 16'h0004, 16'h0005, 16'h0006);
        lock_mem_b = 1'b1;
        open_issue();
        chk("R5", "locked b_valid", b_valid, 0);
        chk("R5", "locked consume", consume, 1);
        @(negedge clk); #1;
        chk("R5", "mem instr in lane a", a_instr, {m, 32'h0});
        chk("R7", "older in a, b next", b_instr, {c, 16'h0});
        chk("R7", "lock pair consume", consume, 2);
        close_issue();
        lock_mem_b = 1'b0;
        do_reset();
        fill6(a, m, c, 16'h0004, 16'h0005, 16'h0006);
        open_issue();
        chk("R5", "unlocked mem on b", b_instr, {m, 16'h0});
        close_issue();
    endtask

    task automatic t_refill_gate();
        do_reset();
        fill6(syl(0, 0, 13'h701), syl(0, 0, 13'h702), syl(0, 0, 13'h703),
              syl(0, 0, 13'h704), syl(0, 0, 13'h705), syl(0, 0, 13'h706));
        mem_valid = 1'b1; mem_data = {syl(1, 0, 13'h7ee), syl(1, 0, 13'h7ff)};
        repeat (2) @(negedge clk);
        mem_valid = 1'b0; #1;
        chk("R2", "refused beat ready", mem_ready, 0);
        open_issue();
        chk("R2", "order after refused", a_instr, {syl(0, 0, 13'h701), 32'h0});
        @(negedge clk); #1;
        chk("R2", "ready at four", mem_ready, 1);
        chk("R7", "drain 2", b_instr, {syl(0, 0, 13'h704), 16'h0});
        @(negedge clk); #1;
        chk("R7", "drain 3", a_instr, {syl(0, 0, 13'h705), 32'h0});
        @(negedge clk); #1;
        chk("R2", "empty after drain", a_valid, 0);
        stall_a = 1'b1;
    endtask

    task automatic t_partial_fill();
        logic [15:0] h = syl(2'b10, 0, 13'h801);
        logic [15:0] x = syl(2'b00, 0, 13'h804);
        do_reset();
        stall_a = 1'b0;
        mem_valid = 1'b1; mem_data = {16'h0802, h};
        @(negedge clk);
        mem_data = {x, 16'h0803}; #1;
        chk("R3", "partial a_valid", a_valid, 0);
        chk("R2", "low half first", a_instr, {h, 16'h0802, 16'h0});
        @(negedge clk);
        mem_valid = 1'b0; #1;
        chk("R3", "complete a_valid", a_valid, 1);
        chk("R4", "3+1 after fill", consume, 4);
        @(negedge clk); #1;
        chk("R7", "emptied", a_valid, 0);
        stall_a = 1'b1;
    endtask

    initial begin
        t_reset();
        t_three_one();
        t_three_two();
        t_short_pairs();
        t_code11_and_one_two();
        t_stall_b();
        t_lock();
        t_refill_gate();
        t_partial_fill();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule